// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block looks at the state of 64 interrupt sources and decides what the processor is asked to service. Each source has a pending bit, an enable bit, a type bit and a 4-bit priority. The type bit selects the fast class (1) or the normal class (0). A source counts as active only when it is pending and enabled. Fast requests bypass any priority check. Normal requests pass through a programmable 5-bit threshold, and one reserved threshold code turns that gate off.

The block has two kinds of output. The two request lines are registered and feed the processor's interrupt inputs. The two vector words are combinational and report the current winner of each class. A register interface elsewhere in the chip can read those words and then clear the winning source. That clearing path is not part of this block.

Top module: `irqArbiter`

## Requirements
- R1: A source takes part in arbitration only when its pending bit and its enable bit are both 1. A pending but disabled source changes no output.
- R2: `fastReq` is 1 when at least one active source has its type bit set to 1 (fast), whatever the priorities and the threshold are.
- R3: When `maskIn` equals 5'h1F, `normReq` is 1 when any active source has its type bit set to 0 (normal), even if that source's priority is 0.
- R4: For any other `maskIn` value, `normReq` is 1 only when some active normal source has a priority strictly greater than `maskIn`. A priority equal to the threshold does not raise the request, and a threshold of 15 or more never raises it.
- R5: The normal winner is the active normal source with the largest priority. When several sources share that priority, the one with the highest source number wins.
- R6: The fast winner is the active fast source with the lowest source number.
- R7: When a class has no active source, its vector output is 32'hFFFF_FFFF.
- R8: The priority of source n is `prioIn[4n+3:4n]`. Seen as eight 32-bit words, this is bits [4*(n%8)+3 : 4*(n%8)] of word n/8.
- R9: `normVector` carries the winning source number in bits [31:16] and its priority, zero-extended, in bits [15:0]. `fastVector` carries the winning source number, zero-extended to 32 bits.
- R10: While `rstN` is 0, both request outputs are 0.
- R11: The request outputs follow their inputs one clock edge later. The vector outputs follow the inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendIn | input | 64 | Pending bit per source |
| enIn | input | 64 | Enable bit per source |
| fastTypeIn | input | 64 | Type bit per source: 1 = fast, 0 = normal |
| prioIn | input | 256 | 4-bit priority per source, source n at bits [4n+3:4n] |
| maskIn | input | 5 | Normal threshold. 5'h1F turns the threshold off |
| fastReq | output | 1 | Registered fast interrupt request |
| normReq | output | 1 | Registered normal interrupt request |
| normVector | output | 32 | {source number, priority} of the normal winner, or all ones when there is none |
| fastVector | output | 32 | Source number of the fast winner, or all ones when there is none |

## Verification
The fast selection and the normal selection read the same pending and enable vectors in the same cycle. The type bit is the only thing that sends a source to one search or the other. The random stimulus therefore mixes both types across dense and sparse pending patterns, so that both request lines and both vectors are often live at once. Every cycle, both vectors and both request lines are compared against bench reference functions. Directed cases then put the normal threshold exactly at, one below and far above the winning priority, and at the off code.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int VEC_W  = 32;
  localparam int HALF_W = 16;

  // Summary flags passed from the datapath to the request control
  typedef struct packed {
    logic fastAny;    // some active fast source exists
    logic normAny;    // some active normal source exists
    logic normAbove;  // best normal priority exceeds the threshold
  } arbFlags_t;
endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic [NUM_SRC-1:0]        pendIn,
  input  logic [NUM_SRC-1:0]        enIn,
  input  logic [NUM_SRC-1:0]        fastTypeIn,
  input  logic [NUM_SRC*PRIO_W-1:0] prioIn,
  input  logic [MASK_W-1:0]         maskIn,
  output arbFlags_t                 flags,
  output logic [VEC_W-1:0]          normVector,
  output logic [VEC_W-1:0]          fastVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CMP_W = (PRIO_W > MASK_W) ? PRIO_W : MASK_W;

  logic [PRIO_W-1:0]  prioOf [NUM_SRC];
  logic [NUM_SRC-1:0] actNorm;
  logic [NUM_SRC-1:0] actFast;
  logic [PRIO_W-1:0]  bestPrio;
  logic [IDX_W-1:0]   bestIdx;
  logic [IDX_W-1:0]   fastIdx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prioOf[g] = prioIn[g*PRIO_W +: PRIO_W];
  end

  assign actNorm = pendIn & enIn & ~fastTypeIn;
  assign actFast = pendIn & enIn & fastTypeIn;

  // Upward scan with >= : a later source with equal priority replaces the earlier one
  always_comb begin
    bestPrio = '0;
    bestIdx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (actNorm[i] && (prioOf[i] >= bestPrio)) begin
        bestPrio = prioOf[i];
        bestIdx  = IDX_W'(i);
      end
    end
  end

  // Downward scan: the last hit is the lowest-numbered source
  always_comb begin
    fastIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (actFast[i]) fastIdx = IDX_W'(i);
    end
  end

  assign flags.fastAny   = |actFast;
  assign flags.normAny   = |actNorm;
  assign flags.normAbove = CMP_W'(bestPrio) > CMP_W'(maskIn);

  assign normVector = flags.normAny ? {HALF_W'(bestIdx), HALF_W'(bestPrio)} : '1;
  assign fastVector = flags.fastAny ? VEC_W'(fastIdx) : '1;
endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
#(
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbFlags_t         flags,
  input  logic [MASK_W-1:0] maskIn,
  output logic              fastReq,
  output logic              normReq
);
  logic maskOff;
  assign maskOff = (maskIn == {MASK_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastReq <= 1'b0;
      normReq <= 1'b0;
    end else begin
      fastReq <= flags.fastAny;
      normReq <= flags.normAny & (maskOff | flags.normAbove);
    end
  end
endmodule

// File: rtl/irqArbiter.sv
module irqArbiter
  import irqArbPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendIn,
  input  logic [NUM_SRC-1:0]        enIn,
  input  logic [NUM_SRC-1:0]        fastTypeIn,
  input  logic [NUM_SRC*PRIO_W-1:0] prioIn,
  input  logic [MASK_W-1:0]         maskIn,
  output logic                      fastReq,
  output logic                      normReq,
  output logic [VEC_W-1:0]          normVector,
  output logic [VEC_W-1:0]          fastVector
);
  arbFlags_t flags;

  irqArbDatapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_dp (
    .pendIn(pendIn), .enIn(enIn), .fastTypeIn(fastTypeIn), .prioIn(prioIn),
    .maskIn(maskIn), .flags(flags), .normVector(normVector), .fastVector(fastVector)
  );

  irqArbControl #(.MASK_W(MASK_W)) u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .maskIn(maskIn),
    .fastReq(fastReq), .normReq(normReq)
  );
endmodule

// File: rtl/irqArbChecker.sv
module irqArbChecker #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_SRC-1:0]        pendIn,
  input logic [NUM_SRC-1:0]        enIn,
  input logic [NUM_SRC-1:0]        fastTypeIn,
  input logic [NUM_SRC*PRIO_W-1:0] prioIn,
  input logic [MASK_W-1:0]         maskIn,
  input logic                      fastReq,
  input logic                      normReq,
  input logic [31:0]               normVector,
  input logic [31:0]               fastVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [MASK_W-1:0] TOP_PRIO = MASK_W'((1 << PRIO_W) - 1);

  logic [NUM_SRC-1:0] aNorm, aFast;
  logic [IDX_W-1:0]   nIdx, fIdx;
  logic               armed;

  assign aNorm = pendIn & enIn & ~fastTypeIn;
  assign aFast = pendIn & enIn & fastTypeIn;
  assign nIdx  = normVector[16 +: IDX_W];
  assign fIdx  = fastVector[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_FAST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (fastReq == $past(|aFast))); // R2
  AST_NORM_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(maskIn == {MASK_W{1'b1}})) |-> (normReq == $past(|aNorm))); // R3
  AST_NORM_HIGH_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(maskIn != {MASK_W{1'b1}}) && $past(maskIn >= TOP_PRIO)) |-> !normReq); // R4
  AST_NO_NORM_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (aNorm == '0) |-> (normVector == 32'hFFFF_FFFF)); // R7
  AST_NO_FAST_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (aFast == '0) |-> (fastVector == 32'hFFFF_FFFF)); // R7
  AST_NORM_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (aNorm != '0) |-> (aNorm[nIdx] && (normVector[31:16] < 16'(NUM_SRC)))); // R5
  AST_NORM_PRIO_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (aNorm != '0) |-> (normVector[15:0] == 16'(prioIn[nIdx*PRIO_W +: PRIO_W]))); // R8
  AST_FAST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    (aFast != '0) |-> (aFast[fIdx] && ((aFast & ~({NUM_SRC{1'b1}} << fIdx)) == '0))); // R6
endmodule

bind irqArbiter irqArbChecker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rstN(rstN), .pendIn(pendIn), .enIn(enIn), .fastTypeIn(fastTypeIn),
  .prioIn(prioIn), .maskIn(maskIn), .fastReq(fastReq), .normReq(normReq),
  .normVector(normVector), .fastVector(fastVector)
);

// File: tb/irqArbiter_tb.sv
`timescale 1ns/1ps
module irqArbiter_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [63:0]  pend = '0, en = '0, typ = '0;
  logic [255:0] prio = '0;
  logic [4:0]   mask = 5'h1F;
  logic         fastReq, normReq;
  logic [31:0]  normVector, fastVector;
  int           nChecks = 0, nFails = 0;
  bit           finished = 1'b0;
  logic         prevFastExp = 1'b0, prevNormExp = 1'b0;

  always #2 clk = ~clk;

  irqArbiter u_dut (
    .clk(clk), .rstN(rstN), .pendIn(pend), .enIn(en), .fastTypeIn(typ),
    .prioIn(prio), .maskIn(mask), .fastReq(fastReq), .normReq(normReq),
    .normVector(normVector), .fastVector(fastVector)
  );

  function automatic logic [3:0] prioOfSrc(int n);
    return prio[(n / 8) * 32 + 4 * (n % 8) +: 4];
  endfunction

  function automatic logic [31:0] refNorm();
    int best = -1, idx = -1;
    for (int i = 63; i >= 0; i--)
      if (pend[i] && en[i] && !typ[i] && int'(prioOfSrc(i)) > best) begin
        best = int'(prioOfSrc(i)); idx = i;
      end
    if (idx < 0) return 32'hFFFF_FFFF;
    return {16'(idx), 16'(best)};
  endfunction

  function automatic logic [31:0] refFast();
    for (int i = 0; i < 64; i++)
      if (pend[i] && en[i] && typ[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic refFastReq();
    return |(pend & en & typ);
  endfunction

  function automatic logic refNormReq();
    for (int i = 0; i < 64; i++)
      if (pend[i] && en[i] && !typ[i] && (mask == 5'h1F || 5'(prioOfSrc(i)) > mask)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setPrio(int n, logic [3:0] p);
    prio[(n / 8) * 32 + 4 * (n % 8) +: 4] = p;
  endtask

  task automatic clearAll();
    pend = '0; en = '0; typ = '0; prio = '0; mask = 5'h1F;
  endtask

  // Inputs were set after a falling edge. Vectors are checked at once,
  // requests before and after the next rising edge.
  task automatic evaluate(string tagN, string tagF);
    logic fe, ne;
    #1;
    check({tagN, " normVector"}, normVector, refNorm());
    check({tagF, " fastVector"}, fastVector, refFast());
    check("R11 fastReq holds before edge", 32'(fastReq), 32'(prevFastExp));
    check("R11 normReq holds before edge", 32'(normReq), 32'(prevNormExp));
    fe = refFastReq(); ne = refNormReq();
    @(posedge clk); @(negedge clk);
    check("R2/R1 fastReq", 32'(fastReq), 32'(fe));
    check((mask == 5'h1F) ? "R3 normReq" : "R4 normReq", 32'(normReq), 32'(ne));
    prevFastExp = fe; prevNormExp = ne;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R10: requests stay low in reset even with active sources
    pend = 64'h1; en = 64'h1; typ = 64'h1;
    repeat (3) @(negedge clk);
    check("R10 fastReq in reset", 32'(fastReq), 32'd0);
    check("R10 normReq in reset", 32'(normReq), 32'd0);
    check("R11 fastVector without clock", fastVector, 32'd0);
    clearAll();
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    clearAll();
    evaluate("R7", "R7");

    clearAll(); pend[5] = 1; typ[5] = 1; pend[7] = 1; setPrio(7, 4'hF);
    evaluate("R1", "R1");

    clearAll(); pend[9] = 1; pend[40] = 1; pend[63] = 1; en = '1; typ = '1; mask = 5'd0;
    evaluate("R7", "R6");

    clearAll(); en = '1;
    pend[3] = 1; pend[20] = 1; pend[50] = 1; pend[10] = 1;
    setPrio(3, 4'd7); setPrio(20, 4'd7); setPrio(50, 4'd7); setPrio(10, 4'd2);
    mask = 5'd6;
    evaluate("R5", "R7");
    mask = 5'd7;
    evaluate("R5", "R7");

    clearAll(); en = '1; pend[2] = 1; pend[33] = 1; mask = 5'h1F;
    evaluate("R3", "R7");
    mask = 5'd0;
    evaluate("R4", "R7");

    clearAll(); en = '1; pend[13] = 1; setPrio(13, 4'hB); mask = 5'd10;
    evaluate("R8/R9", "R7");
    check("R9 normVector fields", normVector, {16'd13, 16'd11});
    check("R8 word1 bit20", 32'(prio[32 + 20 +: 4]), 32'hB);

    clearAll(); en = '1; pend[60] = 1; setPrio(60, 4'hF); mask = 5'd16;
    evaluate("R4", "R7");
    mask = 5'd14;
    evaluate("R4", "R7");

    clearAll(); en = '1; pend = '1; typ = 64'hF0F0_0000_0000_0100;
    for (int i = 0; i < 64; i++) setPrio(i, 4'(i % 13));
    mask = 5'd3;
    evaluate("R5/R9", "R6/R9");

    for (int t = 0; t < 400; t++) begin
      pend = {$urandom, $urandom} & ((t % 2 == 0) ? {$urandom, $urandom} : 64'hFFFF_FFFF_FFFF_FFFF);
      en   = ~({$urandom, $urandom} & {$urandom, $urandom});
      typ  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (t % 5 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      for (int w = 0; w < 8; w++) prio[w*32 +: 32] = $urandom;
      mask = ($urandom % 3 == 0) ? 5'h1F : 5'($urandom % 18);
      evaluate("R5/R8/R9", "R6/R9");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule